// File: doc/BRIEF.md
# PCI Target Transaction Controller

This block is the target side of a 32-bit PCI interface. On the bus side it watches the frame and initiator-ready lines. It captures the multiplexed address and the command at the start of a transaction, then decides whether to claim it. If it claims the transaction, it runs the target handshake: device select, target ready and stop, plus the read-data drive on AD. Bus-master operation and parity are not part of the block. Every bidirectional line is brought out as a separate input, output and output-enable, so that the pad ring can build the tri-state buffers.

On the user side, bursts are turned into a plain strobe interface. This interface has a separate address bus and a write-data bus, takes a read-data bus in, and has one-cycle read and write strobes. A space code says whether an access targets configuration, I/O or memory space, and the block also supplies a synchronised user reset. Each data phase costs the target one wait state. On a read, that cycle lets the user logic return data. On a write, it is the cycle in which the captured word is presented to the user logic.

Top module: `pci_tgt_ctrl`

## Requirements
- R1: While rst_ni is low, tgt_oe_o, ad_oe_o, usr_rd_o, usr_wr_o and usr_rst_no are all 0.
- R2: A transaction is claimed only when its C/BE# value at the address edge is one of the following. For these, the address must also fall in the configured window, where (addr & MASK) == BASE. Unclaimed transactions never bring devsel_no low and produce no strobe.
  - 0010 (I/O read) or 0011 (I/O write), with the address in the I/O window.
  - 0110 (memory read) or 0111 (memory write), with the address in the memory window.
  - 1010 (configuration read) or 1011 (configuration write), with idsel_i high; no window applies.
- R3: In a claimed transaction, the control lines are not driven in the cycle after the address edge. From the next cycle on, they are driven with devsel_no low (medium decode). trdy_no is never low unless devsel_no is low.
- R4: A read data phase starts with one cycle of usr_rd_o, with usr_addr_o equal to the phase address. In the next cycle, trdy_no goes low and ad_o carries the usr_rdata_i sampled at the end of the strobe cycle. ad_oe_o is never high in the cycle after the address edge.
- R5: A write word is taken from ad_i on the edge where irdy_ni and trdy_no are both low. In the following cycle, usr_wr_o is high for one cycle, with that word on usr_wdata_o and the phase address on usr_addr_o. usr_rd_o and usr_wr_o are never high together.
- R6: While the initiator holds irdy_ni high in a data phase, trdy_no stays low and no new strobe is issued.
- R7: In a burst, each data phase addresses the previous phase address plus 4.
- R8: A transfer with frame_ni high is the final one. In the next cycle, devsel_no and trdy_no are driven high with tgt_oe_o still 1; in the cycle after that, tgt_oe_o is 0.
- R9: stop_no is never low while tgt_oe_o is 1.
- R10: During each strobe, usr_space_o gives the claimed space: 01 configuration, 10 I/O, 11 memory.
- R11: usr_rst_no goes high on the second rising clock edge after rst_ni is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Transaction frame from initiator, active low |
| irdy_ni | input | 1 | Initiator ready, active low |
| idsel_i | input | 1 | Configuration select |
| cbe_ni | input | 4 | Command (address phase) / byte enables |
| ad_i | input | 32 | AD bus as seen at the pins |
| ad_o | output | 32 | Read data to drive onto AD |
| ad_oe_o | output | 1 | Enable for the AD drivers |
| trdy_no | output | 1 | Target ready, active low |
| devsel_no | output | 1 | Device select, active low |
| stop_no | output | 1 | Stop request, active low |
| tgt_oe_o | output | 1 | Enable for trdy/devsel/stop drivers |
| usr_rst_no | output | 1 | Synchronised user reset, active low |
| usr_addr_o | output | 32 | Address of the current data phase |
| usr_wdata_o | output | 32 | Write data for the user logic |
| usr_rdata_i | input | 32 | Read data from the user logic |
| usr_rd_o | output | 1 | Read strobe |
| usr_wr_o | output | 1 | Write strobe |
| usr_space_o | output | 2 | Space of the current access |

## Verification
The properties assume that the initiator obeys the bus protocol. It deasserts frame only together with an asserted irdy, it never starts a new transaction before an idle cycle, and it keeps frame low until the final data phase. The bench initiator changes bus lines only on falling edges and releases frame in the same cycle it asserts irdy on the last phase. It leaves at least one idle cycle between transactions. On unclaimed transactions it ends with a master abort that releases frame and then irdy.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [1:0] {
    SP_NONE = 2'b00,
    SP_CFG  = 2'b01,
    SP_IO   = 2'b10,
    SP_MEM  = 2'b11
  } space_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BUSY,   // another target's transaction, wait for bus idle
    S_DEC,    // medium decode slot, lines not driven
    S_RSTB,   // read strobe to user, target wait state
    S_ACK,    // trdy asserted
    S_WSTB,   // write strobe to user, target wait state
    S_TURN    // drive control lines high before release
  } state_e;

  // C/BE# values during the address phase
  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000,
  parameter logic [31:0] IO_MASK  = 32'hFFFF_FF00,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter logic [31:0] MEM_MASK = 32'hFFF0_0000
) (
  input  logic [DW-1:0] ad_i,
  input  logic [3:0]    cbe_ni,
  input  logic          idsel_i,
  output logic          hit_o,
  output logic          rd_cmd_o,
  output space_e        space_o
);
  logic io_win, mem_win;

  assign io_win  = (ad_i & DW'(IO_MASK))  == DW'(IO_BASE);
  assign mem_win = (ad_i & DW'(MEM_MASK)) == DW'(MEM_BASE);

  always_comb begin
    space_o = SP_NONE;
    unique case (cbe_ni)
      CMD_IO_RD,  CMD_IO_WR:  if (io_win)  space_o = SP_IO;
      CMD_MEM_RD, CMD_MEM_WR: if (mem_win) space_o = SP_MEM;
      CMD_CFG_RD, CMD_CFG_WR: if (idsel_i) space_o = SP_CFG;
      default:                space_o = SP_NONE;
    endcase
  end

  assign hit_o    = (space_o != SP_NONE);
  assign rd_cmd_o = ~cbe_ni[0];
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   frame_ni,
  input  logic   irdy_ni,
  input  logic   hit_i,
  input  logic   rd_cmd_i,
  input  space_e space_i,
  output logic   ad_oe_o,
  output logic   tgt_oe_o,
  output logic   trdy_no,
  output logic   devsel_no,
  output logic   stop_no,
  output logic   usr_rd_o,
  output logic   usr_wr_o,
  output space_e space_o,
  output logic   addr_ld_o,
  output logic   addr_inc_o,
  output logic   rd_ld_o,
  output logic   wd_ld_o
);
  state_e st_q, st_d;
  logic   rd_q, last_q;
  space_e space_q;
  logic   xfer;

  assign xfer = (st_q == S_ACK) && !irdy_ni;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (!frame_ni) st_d = hit_i ? S_DEC : S_BUSY;
      S_BUSY: if (frame_ni && irdy_ni) st_d = S_IDLE;
      S_DEC:  st_d = rd_q ? S_RSTB : S_ACK;
      S_RSTB: st_d = S_ACK;
      S_ACK:  if (xfer) st_d = !rd_q ? S_WSTB : (frame_ni ? S_TURN : S_RSTB);
      S_WSTB: st_d = last_q ? S_IDLE : S_ACK;
      S_TURN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      rd_q    <= 1'b0;
      last_q  <= 1'b0;
      space_q <= SP_NONE;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && !frame_ni && hit_i) begin
        rd_q    <= rd_cmd_i;
        space_q <= space_i;
        last_q  <= 1'b0;
      end
      if (xfer) last_q <= frame_ni;
    end
  end

  assign tgt_oe_o   = (st_q == S_RSTB) || (st_q == S_ACK) || (st_q == S_WSTB) || (st_q == S_TURN);
  assign devsel_no  = !((st_q == S_RSTB) || (st_q == S_ACK) || (st_q == S_WSTB && !last_q));
  assign trdy_no    = (st_q != S_ACK);
  assign stop_no    = 1'b1;
  assign ad_oe_o    = rd_q && ((st_q == S_RSTB) || (st_q == S_ACK));
  assign usr_rd_o   = (st_q == S_RSTB);
  assign usr_wr_o   = (st_q == S_WSTB);
  assign space_o    = space_q;
  assign addr_ld_o  = (st_q == S_IDLE) && !frame_ni;
  assign addr_inc_o = (xfer && rd_q) || (st_q == S_WSTB);
  assign rd_ld_o    = (st_q == S_RSTB);
  assign wd_ld_o    = xfer && !rd_q;

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(usr_rd_o && usr_wr_o));
  assert_ad_claimed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (tgt_oe_o && !devsel_no));
  assert_trdy_devsel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_no |-> !devsel_no);
  assert_trdy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && irdy_ni) |=> (!trdy_no && !usr_rd_o && !usr_wr_o));
  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(devsel_no) |=> !tgt_oe_o);
  assert_no_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_oe_o |-> stop_no);
endmodule

// File: rtl/pci_tgt_dpath.sv
module pci_tgt_dpath #(
  parameter int DW       = 32,
  parameter int RST_SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ad_i,
  input  logic [DW-1:0] usr_rdata_i,
  input  logic          addr_ld_i,
  input  logic          addr_inc_i,
  input  logic          rd_ld_i,
  input  logic          wd_ld_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] wdata_o,
  output logic          usr_rst_no
);
  localparam int STEP = DW / 8;

  logic [DW-1:0]       addr_q, rdata_q, wdata_q;
  logic [RST_SYNC-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      rdata_q <= '0;
      wdata_q <= '0;
    end else begin
      if (addr_ld_i)       addr_q <= ad_i;
      else if (addr_inc_i) addr_q <= addr_q + DW'(STEP);
      if (rd_ld_i) rdata_q <= usr_rdata_i;
      if (wd_ld_i) wdata_q <= ad_i;
    end
  end

  generate
    if (RST_SYNC == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= 1'b1;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[RST_SYNC-2:0], 1'b1};
    end
  endgenerate

  assign addr_o     = addr_q;
  assign rdata_o    = rdata_q;
  assign wdata_o    = wdata_q;
  assign usr_rst_no = sync_q[RST_SYNC-1];
endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          RST_SYNC = 2,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000,
  parameter logic [31:0] IO_MASK  = 32'hFFFF_FF00,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter logic [31:0] MEM_MASK = 32'hFFF0_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_ni,
  input  logic          irdy_ni,
  input  logic          idsel_i,
  input  logic [3:0]    cbe_ni,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          trdy_no,
  output logic          devsel_no,
  output logic          stop_no,
  output logic          tgt_oe_o,
  output logic          usr_rst_no,
  output logic [DW-1:0] usr_addr_o,
  output logic [DW-1:0] usr_wdata_o,
  input  logic [DW-1:0] usr_rdata_i,
  output logic          usr_rd_o,
  output logic          usr_wr_o,
  output logic [1:0]    usr_space_o
);
  logic   hit, rd_cmd, addr_ld, addr_inc, rd_ld, wd_ld;
  space_e dec_space, cur_space;

  pci_tgt_decode #(
    .DW(DW), .IO_BASE(IO_BASE), .IO_MASK(IO_MASK),
    .MEM_BASE(MEM_BASE), .MEM_MASK(MEM_MASK)
  ) u_dec (
    .ad_i(ad_i), .cbe_ni(cbe_ni), .idsel_i(idsel_i),
    .hit_o(hit), .rd_cmd_o(rd_cmd), .space_o(dec_space)
  );

  pci_tgt_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_ni(frame_ni), .irdy_ni(irdy_ni),
    .hit_i(hit), .rd_cmd_i(rd_cmd), .space_i(dec_space),
    .ad_oe_o(ad_oe_o), .tgt_oe_o(tgt_oe_o), .trdy_no(trdy_no),
    .devsel_no(devsel_no), .stop_no(stop_no),
    .usr_rd_o(usr_rd_o), .usr_wr_o(usr_wr_o), .space_o(cur_space),
    .addr_ld_o(addr_ld), .addr_inc_o(addr_inc), .rd_ld_o(rd_ld), .wd_ld_o(wd_ld)
  );

  pci_tgt_dpath #(.DW(DW), .RST_SYNC(RST_SYNC)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .ad_i(ad_i), .usr_rdata_i(usr_rdata_i),
    .addr_ld_i(addr_ld), .addr_inc_i(addr_inc), .rd_ld_i(rd_ld), .wd_ld_i(wd_ld),
    .addr_o(usr_addr_o), .rdata_o(ad_o), .wdata_o(usr_wdata_o),
    .usr_rst_no(usr_rst_no)
  );

  assign usr_space_o = cur_space;

  assert_strobe_space_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usr_rd_o || usr_wr_o) |-> (usr_space_o != 2'b00));
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!tgt_oe_o && !ad_oe_o && !usr_rd_o && !usr_wr_o));
endmodule

// File: tb/sim_pci_tgt_ctrl.sv
module sim_pci_tgt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [3:0]  cbe = 4'hF;
  logic [31:0] ad_b = '0;
  logic [31:0] ad_o, usr_addr, usr_wdata, usr_rdata;
  logic        ad_oe, trdy_n, devsel_n, stop_n, tgt_oe, usr_rst_n, usr_rd, usr_wr;
  logic [1:0]  usr_space;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wn = 0, dev_cnt = 0, stop_cnt = 0;
  logic [1:0]  rd_sp;
  logic [31:0] wa [16];
  logic [31:0] wd [16];
  logic [1:0]  wsp [16];

  always #2 clk = ~clk;

  assign usr_rdata = usr_addr ^ 32'h5A5A_A5A5;

  pci_tgt_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .irdy_ni(irdy_n),
    .idsel_i(idsel), .cbe_ni(cbe), .ad_i(ad_b), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .trdy_no(trdy_n), .devsel_no(devsel_n), .stop_no(stop_n), .tgt_oe_o(tgt_oe),
    .usr_rst_no(usr_rst_n), .usr_addr_o(usr_addr), .usr_wdata_o(usr_wdata),
    .usr_rdata_i(usr_rdata), .usr_rd_o(usr_rd), .usr_wr_o(usr_wr),
    .usr_space_o(usr_space)
  );

  always @(posedge clk) if (rst_n) begin
    if (usr_rd) begin rd_cnt++; rd_sp = usr_space; end
    if (usr_wr && wn < 16) begin
      wa[wn] = usr_addr; wd[wn] = usr_wdata; wsp[wn] = usr_space; wn++;
    end
    if (tgt_oe && !devsel_n) dev_cnt++;
    if (tgt_oe && !stop_n) stop_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic logic [31:0] wdat(input logic [31:0] a, input int i);
    return (a * 3) + 32'(i) + 32'h0BAD_0000;
  endfunction

  // claimed transaction: n phases, w initiator wait cycles before the last phase
  task automatic xfer(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                      input int n, input int w, input bit is_wr, input logic [1:0] sp);
    int rd0 = rd_cnt, wn0 = wn;
    @(negedge clk);
    frame_n = 1'b0; ad_b = addr; cbe = cmd; idsel = sel; irdy_n = 1'b1;
    @(negedge clk);
    chk(tgt_oe == 1'b0, "R3", "lines driven in decode slot", 32'(tgt_oe), 0);
    chk(ad_oe == 1'b0, "R4", "AD driven in turnaround", 32'(ad_oe), 0);
    ad_b = '0; cbe = 4'h0; idsel = 1'b0;
    @(negedge clk);
    chk(tgt_oe && !devsel_n, "R3", "devsel not low at medium decode", 32'(devsel_n), 0);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1 && w > 0) begin
        irdy_n = 1'b1;
        for (int k = 0; k < w; k++) begin
          @(negedge clk);
          chk(trdy_n == 1'b0 && !usr_rd && !usr_wr, "R6", "trdy/strobe during irdy wait",
              {29'd0, trdy_n, usr_rd, usr_wr}, 0);
        end
      end
      irdy_n = 1'b0;
      frame_n = (i == n - 1);
      if (is_wr) ad_b = wdat(addr, i);
      for (int k = 0; k < 20 && trdy_n !== 1'b0; k++) @(negedge clk);
      if (!is_wr) begin
        chk(ad_oe == 1'b1, "R4", "AD not driven with trdy", 32'(ad_oe), 1);
        chk(ad_o == ((addr + 32'(4 * i)) ^ 32'h5A5A_A5A5), "R7",
            $sformatf("read data phase %0d", i), ad_o, (addr + 32'(4 * i)) ^ 32'h5A5A_A5A5);
      end
      @(negedge clk);
      irdy_n = 1'b1;
    end
    chk(tgt_oe && devsel_n && trdy_n, "R8", "lines not driven high after last",
        {29'd0, tgt_oe, devsel_n, trdy_n}, 32'h7);
    @(negedge clk);
    chk(tgt_oe == 1'b0, "R8", "lines not released", 32'(tgt_oe), 0);
    if (is_wr) begin
      chk(wn - wn0 == n, "R5", "write strobe count", 32'(wn - wn0), 32'(n));
      for (int i = 0; i < n && wn0 + i < 16; i++) begin
        chk(wa[wn0 + i] == addr + 32'(4 * i), "R7", "write address", wa[wn0 + i], addr + 32'(4 * i));
        chk(wd[wn0 + i] == wdat(addr, i), "R5", "write data", wd[wn0 + i], wdat(addr, i));
        chk(wsp[wn0 + i] == sp, "R10", "write space", 32'(wsp[wn0 + i]), 32'(sp));
      end
    end else begin
      chk(rd_cnt - rd0 == n, "R4", "read strobe count", 32'(rd_cnt - rd0), 32'(n));
      chk(rd_sp == sp, "R10", "read space", 32'(rd_sp), 32'(sp));
    end
  endtask

  task automatic ignored(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                         input string what);
    int d0 = dev_cnt, r0 = rd_cnt, w0 = wn;
    @(negedge clk);
    frame_n = 1'b0; ad_b = addr; cbe = cmd; idsel = sel;
    @(negedge clk);
    ad_b = '0; cbe = 4'h0; idsel = 1'b0; irdy_n = 1'b0;
    repeat (4) @(negedge clk);
    frame_n = 1'b1;
    @(negedge clk);
    irdy_n = 1'b1;
    @(negedge clk);
    chk(dev_cnt == d0, "R2", {what, " claimed"}, 32'(dev_cnt - d0), 0);
    chk(rd_cnt == r0 && wn == w0, "R2", {what, " strobed"}, 32'(rd_cnt - r0 + wn - w0), 0);
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tgt_oe && !ad_oe && !usr_rd && !usr_wr && !usr_rst_n, "R1", "reset state",
        {27'd0, tgt_oe, ad_oe, usr_rd, usr_wr, usr_rst_n}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(usr_rst_n == 1'b0, "R11", "user reset after one edge", 32'(usr_rst_n), 0);
    @(negedge clk);
    chk(usr_rst_n == 1'b1, "R11", "user reset after two edges", 32'(usr_rst_n), 1);

    xfer(4'b1010, 32'h0000_0010, 1'b1, 1, 0, 1'b0, 2'b01);  // cfg read
    xfer(4'b1011, 32'h0000_0004, 1'b1, 1, 0, 1'b1, 2'b01);  // cfg write
    xfer(4'b0010, 32'h0000_1010, 1'b0, 3, 2, 1'b0, 2'b10);  // io burst read, R6 wait
    xfer(4'b0111, 32'h8000_0100, 1'b0, 4, 2, 1'b1, 2'b11);  // mem burst write, R6 wait
    xfer(4'b0011, 32'h0000_10F0, 1'b0, 1, 1, 1'b1, 2'b10);  // io write
    xfer(4'b0110, 32'h800F_FFF0, 1'b0, 2, 0, 1'b0, 2'b11);  // mem burst read
    ignored(4'b1010, 32'h0000_0010, 1'b0, "cfg without idsel");
    ignored(4'b1100, 32'h8000_0000, 1'b0, "unsupported command");
    ignored(4'b0110, 32'h9000_0000, 1'b0, "memory outside window");
    ignored(4'b0011, 32'h0000_2000, 1'b0, "io outside window");
    xfer(4'b0110, 32'h8000_0040, 1'b0, 1, 0, 1'b0, 2'b11);  // claims again after aborts
    chk(stop_cnt == 0, "R9", "stop asserted", 32'(stop_cnt), 0);
    summary();
    $finish;
  end
endmodule